// File: doc/BRIEF.md
# Microcode ROM Power-On Self-Test Controller

This block checks the contents of several on-chip read-only arrays (microcode words, decode tables) right after reset, before any microcode runs. It borrows the functional microprogram counter as its address source, so no separate test address generator exists. For each array it steps the counter from address 0 to the last word, one address per clock. It folds every word read into a multiple-input signature register that starts from a fixed seed. After each array it compares the accumulated signature with an expected constant supplied as a parameter.

The hardware phase always lasts a fixed number of clocks counted from reset release, however quickly the walk itself finishes. When that budget runs out the controller writes a result word, pulses a done flag and loads the microcode entry address into the counter. Normal microcode then takes over and can run its own further self-tests. A strap input lets the board skip the hardware phase.

The controller has five states. ST_STRAP is the first cycle after reset and samples the strap: it goes to ST_RUN when the strap is set and to ST_WALK otherwise. ST_WALK moves on to ST_CHECK once the last address has been read. ST_CHECK returns to ST_WALK for the next array, or goes to ST_HOLD after the final array. ST_HOLD goes to ST_RUN when the cycle budget expires. ST_RUN is final until the next reset.

Top module: `ucode_rom_bist`

## Requirements
- R1: While reset is asserted, test_active is 1, test_done is 0, result_word is all ones (meaning "not yet known") and upc_addr is 0. result_word stays all ones until the hardware phase ends.
- R2: skip_strap is sampled on the first clock edge after reset release. If it is 1, that same edge sets test_done, clears test_active, writes result_word to 0 and loads upc_addr with the microcode entry address. No array is read.
- R3: Arrays are walked in ascending index order, with arr_sel equal to the index. For each array, upc_addr runs through 0 to DEPTH-1, advancing one address per clock. The first walk address appears right after the first edge following reset release. After the last address there is one compare cycle, in which upc_addr stays at DEPTH-1.
- R4: Array data is read combinationally from the current upc_addr. The signature is loaded with SEED at the start of every array. On every walk cycle it becomes (sig shifted left by one) XOR (POLY if the old bit SIG_W-1 was 1) XOR (data zero-extended).
- R5: The signature of array j is compared with bits [j*SIG_W +: SIG_W] of EXP_SIGS.
- R6: The written result_word is 0 when every array matches. Otherwise it is j+1, where j is the lowest-indexed array that mismatched.
- R7: The hardware phase ends on exactly the BUDGET-th clock edge after reset release. test_active stays 1 up to that edge and test_done stays 0 before it. BUDGET must be at least N_ARR*(DEPTH+1)+2.
- R8: test_done is high for exactly one cycle. It rises on the same edge where test_active falls and result_word is written.
- R9: At hand-off upc_addr equals UCODE_ENTRY. From then on, ucode_load loads ucode_target, and otherwise ucode_step adds one. Load has priority over step.
- R10: While test_active is 1, ucode_load, ucode_step and ucode_target have no effect on upc_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| skip_strap | input | 1 | Skip the hardware test when 1 at the first edge after reset |
| arr_rdata | input | N_ARR*DATA_W | Read data of every array at upc_addr; array j in slice j |
| ucode_load | input | 1 | Functional branch: load ucode_target |
| ucode_step | input | 1 | Functional sequential advance |
| ucode_target | input | UPC_W | Functional branch target |
| upc_addr | output | UPC_W | Microprogram counter, also the test address |
| arr_sel | output | SEL_W | Index of the array under test |
| test_active | output | 1 | Hardware test phase in progress |
| test_done | output | 1 | One-cycle pulse at the end of the phase |
| result_word | output | RESULT_W | Result register visible to software |

## Verification
A small configuration (three arrays of sixteen words) is run with clean contents, where only a bit-exact signature model gives a zero result word. It is also run with single-bit corruptions at address 0, at a middle address and at the last address, which shows whether every address is really folded in. Two arrays are corrupted together to confirm that the lowest index is reported. The walk address and array index are compared on every cycle of each run. Constant branch and step requests are held during the test phase to show they are ignored there, and they take effect one cycle after hand-off. A strap run checks the immediate hand-off with a zero result.

// File: rtl/ubist_pkg.sv
package ubist_pkg;

    typedef enum logic [2:0] {
        ST_STRAP = 3'd0,
        ST_WALK  = 3'd1,
        ST_CHECK = 3'd2,
        ST_HOLD  = 3'd3,
        ST_RUN   = 3'd4
    } bist_state_e;

    typedef enum logic [1:0] {
        PC_HOLD  = 2'd0,
        PC_CLEAR = 2'd1,
        PC_NEXT  = 2'd2,
        PC_ENTRY = 2'd3
    } pc_cmd_e;

endpackage

// File: rtl/ubist_misr.sv
module ubist_misr #(
    parameter int              SIG_W  = 32,
    parameter int              DATA_W = 32,
    parameter logic [SIG_W-1:0] POLY  = 32'h0040_0007,
    parameter logic [SIG_W-1:0] SEED  = 32'h1357_9BDF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    output logic [SIG_W-1:0]  sig
);

    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] sig_nxt;
    logic [SIG_W-1:0] din_ext;
    logic             fb;

    assign din_ext = SIG_W'(din);
    assign fb      = sig_q[SIG_W-1];

    // Galois form: each bit takes its lower neighbour, the tap and one data bit
    for (genvar b = 0; b < SIG_W; b++) begin : g_bit
        if (b == 0) begin : g_low
            assign sig_nxt[b] = (fb & POLY[b]) ^ din_ext[b];
        end else begin : g_up
            assign sig_nxt[b] = sig_q[b-1] ^ (fb & POLY[b]) ^ din_ext[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= SEED;
        end else if (seed_load) begin
            sig_q <= SEED;
        end else if (shift_en) begin
            sig_q <= sig_nxt;
        end
    end

    assign sig = sig_q;

    // R4
    seed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> sig == SEED);

endmodule

// File: rtl/ubist_upc.sv
module ubist_upc import ubist_pkg::*; #(
    parameter int               UPC_W       = 12,
    parameter logic [UPC_W-1:0] UCODE_ENTRY = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  pc_cmd_e          tcmd,
    input  logic             f_load,
    input  logic             f_step,
    input  logic [UPC_W-1:0] f_target,
    output logic [UPC_W-1:0] upc
);

    logic [UPC_W-1:0] upc_q;
    logic [UPC_W-1:0] upc_nxt;

    always_comb begin
        upc_nxt = upc_q;
        if (test_mode) begin
            unique case (tcmd)
                PC_HOLD:  upc_nxt = upc_q;
                PC_CLEAR: upc_nxt = '0;
                PC_NEXT:  upc_nxt = upc_q + UPC_W'(1);
                PC_ENTRY: upc_nxt = UCODE_ENTRY;
            endcase
        end else if (f_load) begin
            upc_nxt = f_target;
        end else if (f_step) begin
            upc_nxt = upc_q + UPC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc_q <= '0;
        end else begin
            upc_q <= upc_nxt;
        end
    end

    assign upc = upc_q;

    // R9
    handoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> upc == UCODE_ENTRY);

    // R10
    test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && tcmd == PC_HOLD) |=> $stable(upc));

endmodule

// File: rtl/ubist_seq.sv
module ubist_seq import ubist_pkg::*; #(
    parameter int                     N_ARR    = 4,
    parameter int                     DEPTH    = 64,
    parameter int                     UPC_W    = 12,
    parameter int                     SIG_W    = 32,
    parameter int                     RESULT_W = 32,
    parameter int                     BUDGET   = 1 << 20,
    parameter logic [N_ARR*SIG_W-1:0] EXP_SIGS = '0,
    localparam int                    SEL_W    = (N_ARR > 1) ? $clog2(N_ARR) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                skip_strap,
    input  logic [UPC_W-1:0]    upc,
    input  logic [SIG_W-1:0]    sig,
    output logic                test_mode,
    output pc_cmd_e             tcmd,
    output logic                seed_load,
    output logic                shift_en,
    output logic [SEL_W-1:0]    arr_sel,
    output logic                done,
    output logic [RESULT_W-1:0] result
);

    localparam int               CYC_W    = $clog2(BUDGET + 1);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(BUDGET - 1);
    localparam logic [UPC_W-1:0] LAST_ADR = UPC_W'(DEPTH - 1);
    localparam logic [SEL_W-1:0] LAST_ARR = SEL_W'(N_ARR - 1);

    bist_state_e         state_q;
    bist_state_e         state_nxt;
    logic [SEL_W-1:0]    arr_q;
    logic [CYC_W-1:0]    cyc_q;
    logic [RESULT_W-1:0] fail_q;
    logic                done_q;
    logic [RESULT_W-1:0] result_q;

    logic                at_last_adr;
    logic                at_last_arr;
    logic                budget_end;
    logic                mismatch;
    logic [SIG_W-1:0]    exp_sig;

    assign at_last_adr = (upc == LAST_ADR);
    assign at_last_arr = (arr_q == LAST_ARR);
    assign budget_end  = (cyc_q == LAST_CYC);
    assign exp_sig     = EXP_SIGS[arr_q*SIG_W +: SIG_W];
    assign mismatch    = (sig != exp_sig);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STRAP;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_STRAP: state_nxt = skip_strap ? ST_RUN : ST_WALK;
            ST_WALK:  state_nxt = at_last_adr ? ST_CHECK : ST_WALK;
            ST_CHECK: state_nxt = at_last_arr ? ST_HOLD : ST_WALK;
            ST_HOLD:  state_nxt = budget_end ? ST_RUN : ST_HOLD;
            ST_RUN:   state_nxt = ST_RUN;
        endcase
    end

    // Control outputs
    always_comb begin
        tcmd      = PC_HOLD;
        seed_load = 1'b0;
        shift_en  = 1'b0;
        unique case (state_q)
            ST_STRAP: begin
                tcmd      = skip_strap ? PC_ENTRY : PC_CLEAR;
                seed_load = 1'b1;
            end
            ST_WALK: begin
                shift_en = 1'b1;
                tcmd     = at_last_adr ? PC_HOLD : PC_NEXT;
            end
            ST_CHECK: begin
                if (!at_last_arr) begin
                    tcmd      = PC_CLEAR;
                    seed_load = 1'b1;
                end
            end
            ST_HOLD: tcmd = budget_end ? PC_ENTRY : PC_HOLD;
            ST_RUN:  tcmd = PC_HOLD;
        endcase
    end

    // Progress, failure record and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q    <= '0;
            cyc_q    <= '0;
            fail_q   <= '0;
            done_q   <= 1'b0;
            result_q <= '1;
        end else begin
            done_q <= 1'b0;
            if (state_q != ST_RUN) begin
                cyc_q <= cyc_q + CYC_W'(1);
            end
            unique case (state_q)
                ST_STRAP: begin
                    if (skip_strap) begin
                        done_q   <= 1'b1;
                        result_q <= '0;
                    end
                end
                ST_CHECK: begin
                    if (fail_q == '0 && mismatch) begin
                        fail_q <= RESULT_W'(arr_q) + RESULT_W'(1);
                    end
                    if (!at_last_arr) begin
                        arr_q <= arr_q + SEL_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (budget_end) begin
                        done_q   <= 1'b1;
                        result_q <= fail_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign test_mode = (state_q != ST_RUN);
    assign arr_sel   = arr_q;
    assign done      = done_q;
    assign result    = result_q;

    // R3
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, arr_sel} < (SEL_W + 1)'(N_ARR));

    // R7
    budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> cyc_q < CYC_W'(BUDGET));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!test_mode && $past(test_mode)));

    // R6
    result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result <= RESULT_W'(N_ARR));

endmodule

// File: rtl/ucode_rom_bist.sv
module ucode_rom_bist import ubist_pkg::*; #(
    parameter int                     N_ARR       = 4,
    parameter int                     DEPTH       = 64,
    parameter int                     UPC_W       = 12,
    parameter int                     DATA_W      = 32,
    parameter int                     SIG_W       = 32,
    parameter int                     RESULT_W    = 32,
    parameter int                     BUDGET      = 1 << 20,
    parameter logic [SIG_W-1:0]       POLY        = 32'h0040_0007,
    parameter logic [SIG_W-1:0]       SEED        = 32'h1357_9BDF,
    parameter logic [N_ARR*SIG_W-1:0] EXP_SIGS    = '0,
    parameter logic [UPC_W-1:0]       UCODE_ENTRY = 12'h100,
    localparam int                    SEL_W       = (N_ARR > 1) ? $clog2(N_ARR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    skip_strap,
    input  logic [N_ARR*DATA_W-1:0] arr_rdata,
    input  logic                    ucode_load,
    input  logic                    ucode_step,
    input  logic [UPC_W-1:0]        ucode_target,
    output logic [UPC_W-1:0]        upc_addr,
    output logic [SEL_W-1:0]        arr_sel,
    output logic                    test_active,
    output logic                    test_done,
    output logic [RESULT_W-1:0]     result_word
);

    logic [DATA_W-1:0] arr_word [N_ARR];
    logic [DATA_W-1:0] misr_din;
    logic [SIG_W-1:0]  sig;
    logic              test_mode;
    pc_cmd_e           tcmd;
    logic              seed_load;
    logic              shift_en;

    for (genvar g = 0; g < N_ARR; g++) begin : g_arr
        assign arr_word[g] = arr_rdata[g*DATA_W +: DATA_W];
    end

    always_comb begin
        misr_din = '0;
        for (int i = 0; i < N_ARR; i++) begin
            if (arr_sel == SEL_W'(i)) begin
                misr_din = arr_word[i];
            end
        end
    end

    ubist_seq #(
        .N_ARR    (N_ARR),
        .DEPTH    (DEPTH),
        .UPC_W    (UPC_W),
        .SIG_W    (SIG_W),
        .RESULT_W (RESULT_W),
        .BUDGET   (BUDGET),
        .EXP_SIGS (EXP_SIGS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .skip_strap (skip_strap),
        .upc        (upc_addr),
        .sig        (sig),
        .test_mode  (test_mode),
        .tcmd       (tcmd),
        .seed_load  (seed_load),
        .shift_en   (shift_en),
        .arr_sel    (arr_sel),
        .done       (test_done),
        .result     (result_word)
    );

    ubist_upc #(
        .UPC_W       (UPC_W),
        .UCODE_ENTRY (UCODE_ENTRY)
    ) u_upc (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .tcmd      (tcmd),
        .f_load    (ucode_load),
        .f_step    (ucode_step),
        .f_target  (ucode_target),
        .upc       (upc_addr)
    );

    ubist_misr #(
        .SIG_W  (SIG_W),
        .DATA_W (DATA_W),
        .POLY   (POLY),
        .SEED   (SEED)
    ) u_misr (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .shift_en  (shift_en),
        .din       (misr_din),
        .sig       (sig)
    );

    assign test_active = test_mode;

endmodule

// File: tb/ucode_rom_bist_bench.sv
`timescale 1ns/1ps
module ucode_rom_bist_bench;

    localparam int              NARR   = 3;
    localparam int              DEPTH  = 16;
    localparam int              UW     = 6;
    localparam int              DW     = 8;
    localparam int              SW     = 16;
    localparam int              RW     = 8;
    localparam int              BUDGET = 64;
    localparam logic [SW-1:0]   POLY   = 16'h6801;
    localparam logic [SW-1:0]   SEED   = 16'hACE1;
    localparam logic [UW-1:0]   ENTRY  = 6'd40;

    function automatic logic [DW-1:0] rom_base(int j, int k);
        return DW'((k * 29 + j * 71 + 13) ^ (k << 3));
    endfunction

    function automatic logic [SW-1:0] sig_step(logic [SW-1:0] s, logic [DW-1:0] d);
        logic [SW-1:0] n;
        n = {s[SW-2:0], 1'b0} ^ (s[SW-1] ? POLY : '0) ^ SW'(d);
        return n;
    endfunction

    function automatic logic [NARR*SW-1:0] calc_exp();
        logic [NARR*SW-1:0] v;
        logic [SW-1:0]      s;
        v = '0;
        for (int j = 0; j < NARR; j++) begin
            s = SEED;
            for (int k = 0; k < DEPTH; k++) begin
                s = sig_step(s, rom_base(j, k));
            end
            v[j*SW +: SW] = s;
        end
        return v;
    endfunction

    localparam logic [NARR*SW-1:0] EXP = calc_exp();

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 skip_strap = 1'b0;
    logic [NARR*DW-1:0]   arr_rdata;
    logic                 ucode_load = 1'b0;
    logic                 ucode_step = 1'b0;
    logic [UW-1:0]        ucode_target = '0;
    logic [UW-1:0]        upc_addr;
    logic [1:0]           arr_sel;
    logic                 test_active;
    logic                 test_done;
    logic [RW-1:0]        result_word;

    logic [NARR-1:0]      corrupt = '0;
    logic [UW-1:0]        bad_addr = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int j = 0; j < NARR; j++) begin
            arr_rdata[j*DW +: DW] = rom_base(j, int'(upc_addr))
                ^ ((corrupt[j] && upc_addr == bad_addr) ? 8'h40 : 8'h00);
        end
    end

    ucode_rom_bist #(
        .N_ARR(NARR), .DEPTH(DEPTH), .UPC_W(UW), .DATA_W(DW), .SIG_W(SW),
        .RESULT_W(RW), .BUDGET(BUDGET), .POLY(POLY), .SEED(SEED),
        .EXP_SIGS(EXP), .UCODE_ENTRY(ENTRY)
    ) u_ucode_rom_bist (
        .clk(clk), .rst_n(rst_n), .skip_strap(skip_strap), .arr_rdata(arr_rdata),
        .ucode_load(ucode_load), .ucode_step(ucode_step), .ucode_target(ucode_target),
        .upc_addr(upc_addr), .arr_sel(arr_sel), .test_active(test_active),
        .test_done(test_done), .result_word(result_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One complete test phase from reset
    task automatic run_phase(input logic [NARR-1:0] cor, input logic [UW-1:0] bad,
                             input bit skip, input bit noise, input int code);
        int last;
        rst_n        = 1'b0;
        corrupt      = cor;
        bad_addr     = bad;
        skip_strap   = skip;
        ucode_load   = noise;
        ucode_step   = noise;
        ucode_target = 6'd5;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(test_active == 1'b1, "R1", "active in reset", int'(test_active), 1);
        chk(test_done == 1'b0, "R1", "done in reset", int'(test_done), 0);
        chk(result_word == 8'hFF, "R1", "result in reset", int'(result_word), 255);
        chk(upc_addr == '0, "R1", "upc in reset", int'(upc_addr), 0);
        rst_n = 1'b1;
        last = skip ? 3 : BUDGET + 1;
        for (int e = 0; e <= last; e++) begin
            if (skip) begin
                if (e == 0) begin
                    chk(test_active, "R2", "active before strap edge", int'(test_active), 1);
                end else begin
                    // R2 immediate hand-off
                    chk(!test_active, "R2", "active after strap", int'(test_active), 0);
                    chk(result_word == '0, "R2", "skip result", int'(result_word), 0);
                    chk(upc_addr == ENTRY, "R2", "skip upc", int'(upc_addr), int'(ENTRY));
                    chk(test_done == (e == 1), "R8", "skip done pulse", int'(test_done), int'(e == 1));
                end
            end else if (e < BUDGET) begin
                int ea, es;
                if (e == 0) begin
                    ea = 0; es = 0;
                end else if (e <= NARR * (DEPTH + 1)) begin
                    es = (e - 1) / (DEPTH + 1);
                    ea = (e - 1) % (DEPTH + 1);
                    if (ea == DEPTH) ea = DEPTH - 1;
                end else begin
                    ea = DEPTH - 1; es = NARR - 1;
                end
                // R3 walk order, R10 functional requests ignored
                chk(upc_addr == UW'(ea), noise ? "R10" : "R3", "walk addr", int'(upc_addr), ea);
                chk(arr_sel == 2'(es), "R3", "array index", int'(arr_sel), es);
                chk(test_active && !test_done, "R7", "phase running", int'({test_active, test_done}), 2);
                chk(result_word == 8'hFF, "R1", "result pending", int'(result_word), 255);
            end else if (e == BUDGET) begin
                chk(test_done && !test_active, "R7", "phase end edge", int'({test_active, test_done}), 1);
                chk(result_word == RW'(code), "R6", "result code", int'(result_word), code);
                chk(upc_addr == ENTRY, "R9", "entry at hand-off", int'(upc_addr), int'(ENTRY));
            end else begin
                chk(!test_done, "R8", "done one cycle", int'(test_done), 0);
                chk(upc_addr == (noise ? 6'd5 : ENTRY), "R9", "first functional cycle",
                    int'(upc_addr), noise ? 5 : int'(ENTRY));
            end
            @(posedge clk);
            @(negedge clk);
        end
        ucode_load = 1'b0;
        ucode_step = 1'b0;
    endtask

    initial begin
        // R4 R5 clean contents: exact signature model gives zero
        run_phase(3'b000, 6'd0, 1'b0, 1'b0, 0);
        // R9 functional counter after hand-off
        ucode_step = 1'b1;
        @(negedge clk);
        chk(upc_addr == ENTRY + 6'd1, "R9", "step", int'(upc_addr), int'(ENTRY) + 1);
        ucode_load = 1'b1; ucode_target = 6'd9;
        @(negedge clk);
        chk(upc_addr == 6'd9, "R9", "load over step", int'(upc_addr), 9);
        ucode_load = 1'b0; ucode_step = 1'b0;
        @(negedge clk);
        chk(upc_addr == 6'd9, "R9", "idle hold", int'(upc_addr), 9);
        // R10 requests held during test, R4 first address folded in
        run_phase(3'b001, 6'd0, 1'b0, 1'b1, 1);
        // R6 single corruption mid array 2
        run_phase(3'b100, 6'd7, 1'b0, 1'b0, 3);
        // R6 lowest failing array reported, last address folded in
        run_phase(3'b110, 6'd15, 1'b0, 1'b0, 2);
        // R5 slice per array: array 1 only
        run_phase(3'b010, 6'd3, 1'b0, 1'b0, 2);
        // R2 strap skip even with broken contents
        run_phase(3'b111, 6'd2, 1'b1, 1'b0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule